// File: doc/BRIEF.md
# Trigger Sequence Emulator

This block stands in for a central trigger when a front-end readout chain is tested on its own. It steps through a stored program of up to 32 entries. Each entry names one of seven legal sequence types and carries its own L1 and L2 message data. On each accepted start it plays that sequence: an L0 pulse, then an L1 pulse, then an explicit L2 accept or L2 reject, each at a fixed latency after the emulated interaction. An L1 rejection is signalled only by the absence of L1 and L2.

Starts come from one of four selectable sources: a prescaled bunch-crossing tick, a pseudo-random generator with a programmable probability, the rising edge of an external pulser, or a software request. A start that arrives while a sequence is still active is dropped and counted.

Two error modes let the front end practise recovery. A forced error corrupts the next sequence whatever its entry says. A random error corrupts an entry that is marked error-prone, with a programmable probability. A corrupted sequence raises an error flag in its first cycle and loses its L2 message. Serialization of the pulses and messages is handled outside this block.

Top module: `trig_seq_emu`

## Requirements
- R1: After reset, all pulse outputs (`l0_o`, `l1_o`, `l2_acc_o`, `l2_rej_o`, `err_o`) are low and `busy_rej_cnt_o` is 0.
- R2: An accepted start whose entry code is 0 to 6 makes `l0_o` high for exactly one cycle, L0_LAT cycles after the accepting edge. A start is accepted at a rising clock edge where the start is present, `run_en` is high and no sequence is active.
- R3: Codes 1 to 6 make `l1_o` pulse L1_LAT cycles after acceptance, with the entry's L1 data on `l1_data_o`. Code 0 (L0 only, i.e. L1 rejected) gives no L1 pulse and no L2 message.
- R4: Codes 1, 3, 4, 5 and 6 (physics accept, calibration, software, start-of-run, end-of-run) end with a one-cycle `l2_acc_o` pulse L2_LAT cycles after acceptance. Code 2 ends with `l2_rej_o` at the same time. In both cases the entry's L2 data is on `l2_data_o`.
- R5: During every output pulse of a sequence, `seq_code_o` shows that sequence's 3-bit code.
- R6: A start that arrives while a sequence is active (from acceptance until its last slot, which is L2_LAT for codes 1 to 6 and L1_LAT otherwise) produces no pulses and increments `busy_rej_cnt_o` by one.
- R7: `src_sel` picks the start source. 0 is a prescaled tick every `bc_div`+1 cycles, counted from the cycle the source is selected. 1 is random: a start each cycle in which a 16-bit LFSR value is less than or equal to `rnd_thresh`. 2 is a rising edge of `ext_pulse`. 3 is `sw_req` high.
- R8: Entries are played in address order from 0. The pointer returns to 0 after entry `prog_len`-1.
- R9: A `force_err` pulse marks the next accepted sequence as corrupted. It pulses `err_o` in the acceptance cycle (latency 0) and suppresses the sequence's L2 message. L0 and L1 still occur.
- R10: With `rnd_err_en` high, an entry whose error bit is set is corrupted (as in R9) when the error LFSR is at or below `err_thresh`. A threshold of 0xFFFF always corrupts it, a threshold of 0 never does, and entries without the bit are never randomly corrupted.
- R11: Code 7 is illegal. It produces no pulses but keeps the emulator active until L1_LAT.
- R12: While `run_en` is low, starts are ignored and not counted, and the program pointer returns to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bunch crossing per cycle |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables emulation; low rewinds the program |
| src_sel | input | 2 | Start source select (0 tick, 1 random, 2 external, 3 software) |
| bc_div | input | DIV_W | Prescale: tick every bc_div+1 cycles |
| rnd_thresh | input | 16 | Random start probability threshold |
| ext_pulse | input | 1 | External pulser, rising edge starts |
| sw_req | input | 1 | Software start request |
| prog_we | input | 1 | Program entry write strobe |
| prog_addr | input | AW | Program entry address |
| prog_code | input | 3 | Sequence code to write |
| prog_l1_data | input | L1W | L1 message data to write |
| prog_l2_data | input | L2W | L2 message data to write |
| prog_err | input | 1 | Error-prone flag to write |
| prog_len | input | AW+1 | Number of program entries in use |
| force_err | input | 1 | Corrupt the next sequence |
| rnd_err_en | input | 1 | Enable random corruption of error-prone entries |
| err_thresh | input | 16 | Random error probability threshold |
| l0_o | output | 1 | L0 pulse |
| l1_o | output | 1 | L1 accept pulse |
| l2_acc_o | output | 1 | L2 accept message strobe |
| l2_rej_o | output | 1 | L2 reject message strobe |
| err_o | output | 1 | Corrupted-sequence flag |
| seq_code_o | output | 3 | Code of the running sequence |
| l1_data_o | output | L1W | L1 message data |
| l2_data_o | output | L2W | L2 message data |
| busy_rej_cnt_o | output | CNT_W | Count of starts dropped while busy |

## Verification
The embedded properties assume the clock runs continuously and that reset is held for at least one edge. They also assume that program entries are rewritten only while no sequence is active, and that `prog_len` never exceeds the program depth. The bench keeps to these assumptions. It writes entries and changes thresholds only between sequences, it drives each software and external start from a negative edge, and it lets every sequence finish before it reprograms. It also switches the start source only on a negative edge, so the prescaler and random phases stay predictable.

// File: rtl/tse_pkg.sv
package tse_pkg;

    typedef enum logic [2:0] {
        SEQ_L0_ONLY  = 3'd0,
        SEQ_PHYS_ACC = 3'd1,
        SEQ_PHYS_REJ = 3'd2,
        SEQ_CALIB    = 3'd3,
        SEQ_SOFT     = 3'd4,
        SEQ_RUN_BEG  = 3'd5,
        SEQ_RUN_END  = 3'd6,
        SEQ_ILLEGAL  = 3'd7
    } seq_code_e;

    typedef enum logic [1:0] {
        SRC_TICK = 2'd0,
        SRC_RAND = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_SW   = 2'd3
    } start_src_e;

    localparam int unsigned LFSR_W = 16;

    function automatic logic code_has_l0(input logic [2:0] c);
        return c != SEQ_ILLEGAL;
    endfunction

    function automatic logic code_has_l1(input logic [2:0] c);
        return (c != SEQ_L0_ONLY) && (c != SEQ_ILLEGAL);
    endfunction

    function automatic logic code_l2_accept(input logic [2:0] c);
        return code_has_l1(c) && (c != SEQ_PHYS_REJ);
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] x);
        return {x[LFSR_W-2:0], x[15] ^ x[14] ^ x[12] ^ x[3]};
    endfunction

endpackage

// File: rtl/tse_lfsr.sv
module tse_lfsr
    import tse_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= SEED;
        else     q <= lfsr_step(q);
    end
endmodule

// File: rtl/tse_start_sel.sv
module tse_start_sel
    import tse_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        src_sel,
    input  logic [DIV_W-1:0]  bc_div,
    input  logic [LFSR_W-1:0] rnd_thresh,
    input  logic              ext_pulse,
    input  logic              sw_req,
    output logic              start_o
);
    logic [DIV_W-1:0]  tick_cnt;
    logic              ext_q;
    logic [LFSR_W-1:0] rnd_val;

    tse_lfsr #(.SEED(16'hACE1)) u_rnd (.clk(clk), .rst(rst), .q(rnd_val));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            ext_q    <= 1'b0;
        end else begin
            ext_q <= ext_pulse;
            if (src_sel == SRC_TICK)
                tick_cnt <= (tick_cnt == bc_div) ? '0 : tick_cnt + 1'b1;
            else
                tick_cnt <= '0;
        end
    end

    always_comb begin
        unique case (src_sel)
            SRC_TICK: start_o = (tick_cnt == bc_div);
            SRC_RAND: start_o = (rnd_val <= rnd_thresh);
            SRC_EXT:  start_o = ext_pulse & ~ext_q;
            default:  start_o = sw_req;
        endcase
    end
endmodule

// File: rtl/tse_prog_mem.sv
module tse_prog_mem #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned L1W   = 8,
    parameter int unsigned L2W   = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [2:0]     wcode,
    input  logic [L1W-1:0] wl1,
    input  logic [L2W-1:0] wl2,
    input  logic           werr,
    input  logic [AW-1:0]  raddr,
    output logic [2:0]     rcode,
    output logic [L1W-1:0] rl1,
    output logic [L2W-1:0] rl2,
    output logic           rerr
);
    typedef struct packed {
        logic [2:0]     code;
        logic [L1W-1:0] l1d;
        logic [L2W-1:0] l2d;
        logic           err;
    } entry_t;

    entry_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && waddr == AW'(i))
                mem[i] <= '{code: wcode, l1d: wl1, l2d: wl2, err: werr};
        end
    end

    assign rcode = mem[raddr].code;
    assign rl1   = mem[raddr].l1d;
    assign rl2   = mem[raddr].l2d;
    assign rerr  = mem[raddr].err;
endmodule

// File: rtl/tse_engine.sv
module tse_engine
    import tse_pkg::*;
#(
    parameter int unsigned L0_LAT = 48,
    parameter int unsigned L1_LAT = 260,
    parameter int unsigned L2_LAT = 3520,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned L1W    = 8,
    parameter int unsigned L2W    = 8,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned TW    = $clog2(L2_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run_en,
    input  logic [AW:0]       prog_len,
    input  logic              force_err,
    input  logic              rnd_err_en,
    input  logic [LFSR_W-1:0] err_thresh,
    output logic [AW-1:0]     rd_addr,
    input  logic [2:0]        rd_code,
    input  logic [L1W-1:0]    rd_l1,
    input  logic [L2W-1:0]    rd_l2,
    input  logic              rd_err,
    output logic              l0_o,
    output logic              l1_o,
    output logic              l2_acc_o,
    output logic              l2_rej_o,
    output logic              err_o,
    output logic [2:0]        seq_code_o,
    output logic [L1W-1:0]    l1_data_o,
    output logic [L2W-1:0]    l2_data_o,
    output logic [CNT_W-1:0]  busy_cnt_o
);
    typedef struct packed {
        logic [2:0]     code;
        logic [L1W-1:0] l1d;
        logic [L2W-1:0] l2d;
        logic           bad;
    } run_t;

    logic              active;
    logic [TW-1:0]     tmr;
    run_t              cur;
    logic [AW-1:0]     ptr;
    logic              force_pend;
    logic [CNT_W-1:0]  busy_cnt;
    logic [LFSR_W-1:0] err_val;
    logic              accept, dropped, rnd_hit;
    logic [TW-1:0]     last_slot;
    logic [AW:0]       ptr_inc;

    tse_lfsr #(.SEED(16'h5EED)) u_err (.clk(clk), .rst(rst), .q(err_val));

    assign accept    = start && run_en && !active;
    assign dropped   = start && run_en && active;
    assign rnd_hit   = rd_err && rnd_err_en && (err_val <= err_thresh);
    assign last_slot = code_has_l1(cur.code) ? TW'(L2_LAT) : TW'(L1_LAT);
    assign ptr_inc   = {1'b0, ptr} + 1'b1;
    assign rd_addr   = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            tmr        <= '0;
            cur        <= '0;
            ptr        <= '0;
            force_pend <= 1'b0;
            busy_cnt   <= '0;
        end else begin
            if (dropped) busy_cnt <= busy_cnt + 1'b1;
            if (!run_en) ptr <= '0;
            if (accept) begin
                active     <= 1'b1;
                tmr        <= '0;
                cur        <= '{code: rd_code, l1d: rd_l1, l2d: rd_l2,
                                bad: force_pend | rnd_hit};
                force_pend <= force_err;
                ptr        <= (ptr_inc >= prog_len) ? '0 : ptr_inc[AW-1:0];
            end else begin
                if (force_err) force_pend <= 1'b1;
                if (active) begin
                    if (tmr == last_slot) active <= 1'b0;
                    else                  tmr    <= tmr + 1'b1;
                end
            end
        end
    end

    assign l0_o       = active && tmr == TW'(L0_LAT) && code_has_l0(cur.code);
    assign l1_o       = active && tmr == TW'(L1_LAT) && code_has_l1(cur.code);
    assign l2_acc_o   = active && tmr == TW'(L2_LAT) && !cur.bad && code_l2_accept(cur.code);
    assign l2_rej_o   = active && tmr == TW'(L2_LAT) && !cur.bad && cur.code == SEQ_PHYS_REJ;
    assign err_o      = active && tmr == '0 && cur.bad;
    assign seq_code_o = cur.code;
    assign l1_data_o  = cur.l1d;
    assign l2_data_o  = cur.l2d;
    assign busy_cnt_o = busy_cnt;

    // Helpers for the protocol-order checks below.
    logic seen_l0, seen_l1;
    always_ff @(posedge clk) begin
        if (rst || accept) begin
            seen_l0 <= 1'b0;
            seen_l1 <= 1'b0;
        end else begin
            if (l0_o) seen_l0 <= 1'b1;
            if (l1_o) seen_l1 <= 1'b1;
        end
    end

    a_r2_l0_single_cycle: assert property (@(posedge clk) disable iff (rst)
        l0_o |=> !l0_o);
    a_r3_l1_after_l0: assert property (@(posedge clk) disable iff (rst)
        l1_o |-> seen_l0);
    a_r4_l2_after_l1: assert property (@(posedge clk) disable iff (rst)
        (l2_acc_o || l2_rej_o) |-> seen_l1);
    a_r4_one_l2_kind: assert property (@(posedge clk) disable iff (rst)
        $onehot0({l2_acc_o, l2_rej_o, l1_o, l0_o}));
    a_r6_busy_count: assert property (@(posedge clk) disable iff (rst)
        (start && run_en && active) |=> busy_cnt == $past(busy_cnt) + 1'b1);
    a_r12_no_count_idle: assert property (@(posedge clk) disable iff (rst)
        (!run_en || !start) |=> $stable(busy_cnt));
endmodule

// File: rtl/trig_seq_emu.sv
module trig_seq_emu
    import tse_pkg::*;
#(
    parameter int unsigned L0_LAT = 48,
    parameter int unsigned L1_LAT = 260,
    parameter int unsigned L2_LAT = 3520,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned L1W    = 8,
    parameter int unsigned L2W    = 8,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] bc_div,
    input  logic [15:0]      rnd_thresh,
    input  logic             ext_pulse,
    input  logic             sw_req,
    input  logic             prog_we,
    input  logic [AW-1:0]    prog_addr,
    input  logic [2:0]       prog_code,
    input  logic [L1W-1:0]   prog_l1_data,
    input  logic [L2W-1:0]   prog_l2_data,
    input  logic             prog_err,
    input  logic [AW:0]      prog_len,
    input  logic             force_err,
    input  logic             rnd_err_en,
    input  logic [15:0]      err_thresh,
    output logic             l0_o,
    output logic             l1_o,
    output logic             l2_acc_o,
    output logic             l2_rej_o,
    output logic             err_o,
    output logic [2:0]       seq_code_o,
    output logic [L1W-1:0]   l1_data_o,
    output logic [L2W-1:0]   l2_data_o,
    output logic [CNT_W-1:0] busy_rej_cnt_o
);
    logic           start;
    logic [AW-1:0]  rd_addr;
    logic [2:0]     rd_code;
    logic [L1W-1:0] rd_l1;
    logic [L2W-1:0] rd_l2;
    logic           rd_err;

    tse_start_sel #(.DIV_W(DIV_W)) u_src (
        .clk(clk), .rst(rst), .src_sel(src_sel), .bc_div(bc_div),
        .rnd_thresh(rnd_thresh), .ext_pulse(ext_pulse), .sw_req(sw_req),
        .start_o(start)
    );

    tse_prog_mem #(.DEPTH(DEPTH), .L1W(L1W), .L2W(L2W)) u_mem (
        .clk(clk), .rst(rst), .we(prog_we), .waddr(prog_addr),
        .wcode(prog_code), .wl1(prog_l1_data), .wl2(prog_l2_data),
        .werr(prog_err), .raddr(rd_addr), .rcode(rd_code), .rl1(rd_l1),
        .rl2(rd_l2), .rerr(rd_err)
    );

    tse_engine #(
        .L0_LAT(L0_LAT), .L1_LAT(L1_LAT), .L2_LAT(L2_LAT), .DEPTH(DEPTH),
        .L1W(L1W), .L2W(L2W), .CNT_W(CNT_W)
    ) u_eng (
        .clk(clk), .rst(rst), .start(start), .run_en(run_en),
        .prog_len(prog_len), .force_err(force_err), .rnd_err_en(rnd_err_en),
        .err_thresh(err_thresh), .rd_addr(rd_addr), .rd_code(rd_code),
        .rd_l1(rd_l1), .rd_l2(rd_l2), .rd_err(rd_err),
        .l0_o(l0_o), .l1_o(l1_o), .l2_acc_o(l2_acc_o), .l2_rej_o(l2_rej_o),
        .err_o(err_o), .seq_code_o(seq_code_o), .l1_data_o(l1_data_o),
        .l2_data_o(l2_data_o), .busy_cnt_o(busy_rej_cnt_o)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !(l0_o || l1_o || l2_acc_o || l2_rej_o || err_o) && busy_rej_cnt_o == '0);
endmodule

// File: tb/tb_trig_seq_emu.sv
`timescale 1ns/1ps
module tb_trig_seq_emu;
    localparam int L0 = 4, L1 = 10, L2 = 20;
    localparam int K_L0 = 0, K_L1 = 1, K_L2A = 2, K_L2R = 3, K_ERR = 4;

    logic clk = 0, rst = 1;
    logic run_en = 0, ext_pulse = 0, sw_req = 0, prog_we = 0, prog_err = 0;
    logic force_err = 0, rnd_err_en = 0;
    logic [1:0]  src_sel = 2'd3;
    logic [15:0] bc_div = 16'd0, rnd_thresh = 16'd0, err_thresh = 16'd0;
    logic [4:0]  prog_addr = 0;
    logic [2:0]  prog_code = 0;
    logic [7:0]  prog_l1_data = 0, prog_l2_data = 0;
    logic [5:0]  prog_len = 6'd8;
    logic l0_o, l1_o, l2_acc_o, l2_rej_o, err_o;
    logic [2:0]  seq_code_o;
    logic [7:0]  l1_data_o, l2_data_o;
    logic [15:0] busy_rej_cnt_o;

    trig_seq_emu #(.L0_LAT(L0), .L1_LAT(L1), .L2_LAT(L2)) dut (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    int checks = 0, errors = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int t; int kind; int code; int data; string req; } ev_t;
    ev_t q[$];

    function automatic void push(int t, int kind, int code, int data, string req);
        ev_t e;
        e.t = t; e.kind = kind; e.code = code; e.data = data; e.req = req;
        q.push_back(e);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    task automatic observe(int kind, int data);
        ev_t e;
        if (q.size() == 0) begin
            check(0, "R3", "unexpected pulse kind", kind, -1);
            return;
        end
        e = q.pop_front();
        check(e.kind == kind, e.req, "pulse kind", kind, e.kind);
        check(e.t == cyc, e.req, "pulse cycle", cyc, e.t);
        check(int'(seq_code_o) == e.code, "R5", "sequence code", int'(seq_code_o), e.code);
        check(data == e.data, e.req, "message data", data, e.data);
    endtask

    always @(negedge clk) if (!rst) begin
        if (err_o)    observe(K_ERR, 0);
        if (l0_o)     observe(K_L0, 0);
        if (l1_o)     observe(K_L1, int'(l1_data_o));
        if (l2_acc_o) observe(K_L2A, int'(l2_data_o));
        if (l2_rej_o) observe(K_L2R, int'(l2_data_o));
    end

    // Driver helpers
    function automatic void expect_seq(int c0, int code, int l1d, int l2d, bit bad);
        if (bad) push(c0, K_ERR, code, 0, "R9");
        if (code != 7) push(c0 + L0, K_L0, code, 0, "R2");
        if (code >= 1 && code <= 6) begin
            push(c0 + L1, K_L1, code, l1d, "R3");
            if (!bad) push(c0 + L2, code == 2 ? K_L2R : K_L2A, code, l2d, "R4");
        end
    endfunction

    task automatic write_entry(int a, int code, bit e);
        @(negedge clk);
        prog_we = 1; prog_addr = 5'(a); prog_code = 3'(code);
        prog_l1_data = 8'(8'h10 + a); prog_l2_data = 8'(8'hA0 + a); prog_err = e;
        @(negedge clk);
        prog_we = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Issues one software start at the next negedge; returns acceptance cycle.
    task automatic sw_start(output int c0);
        @(negedge clk);
        sw_req = 1; c0 = cyc + 1;
        @(negedge clk);
        sw_req = 0;
    endtask

    task automatic run_entry(int a, bit bad);
        int c0;
        sw_start(c0);
        expect_seq(c0, a == 9 ? 0 : a, 8'h10 + a, 8'hA0 + a, bad);
        idle(L2 + 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c0, n;
        idle(3);
        rst = 0;
        // R1: quiet after reset
        @(negedge clk);
        check(!(l0_o | l1_o | l2_acc_o | l2_rej_o | err_o), "R1", "pulses after reset", 1, 0);
        check(busy_rej_cnt_o == 0, "R1", "busy count after reset", int'(busy_rej_cnt_o), 0);
        for (int i = 0; i < 8; i++) write_entry(i, i, 0);
        run_en = 1;
        // R2 R3 R4 R11: every code in address order
        for (int i = 0; i < 8; i++) run_entry(i, 0);
        // R8: wrap to entry 0
        run_entry(0, 0);
        // R6: starts during the active sequence (entry 1) are dropped
        sw_start(c0);
        expect_seq(c0, 1, 8'h11, 8'hA1, 0);
        idle(1);
        sw_req = 1; @(negedge clk); sw_req = 0;
        idle(L1 - 1);
        sw_req = 1; @(negedge clk); sw_req = 0;
        idle(L2);
        check(busy_rej_cnt_o == 2, "R6", "busy reject count", int'(busy_rej_cnt_o), 2);
        // R9: forced error on entry 2
        @(negedge clk); force_err = 1; @(negedge clk); force_err = 0;
        run_entry(2, 1);
        // R10: random error on error-prone entry 3, none on entry 4, none at threshold 0 on 5
        write_entry(3, 3, 1);
        rnd_err_en = 1; err_thresh = 16'hFFFF;
        run_entry(3, 1);
        run_entry(4, 0);
        write_entry(5, 5, 1);
        err_thresh = 16'h0000;
        run_entry(5, 0);
        rnd_err_en = 0;
        // R7: external rising edge, held three cycles -> one start (entry 6)
        @(negedge clk);
        src_sel = 2'd2; ext_pulse = 1; c0 = cyc + 1;
        expect_seq(c0, 6, 8'h16, 8'hA6, 0);
        idle(3); ext_pulse = 0;
        idle(L2 + 3);
        // R7: prescaled tick, period 31 -> entries 7 (silent) and 0
        @(negedge clk);
        src_sel = 2'd0; bc_div = 16'd30; n = cyc;
        expect_seq(n + 31, 7, 0, 0, 0);
        expect_seq(n + 62, 0, 0, 0, 0);
        while (cyc < n + 63) @(negedge clk);
        src_sel = 2'd3;
        idle(L2 + 3);
        // R7: random source, threshold 0 never fires, 0xFFFF fires at once (entry 1)
        @(negedge clk); rnd_thresh = 16'h0000; src_sel = 2'd1;
        idle(20);
        rnd_thresh = 16'hFFFF; c0 = cyc + 1;
        expect_seq(c0, 1, 8'h11, 8'hA1, 0);
        @(negedge clk); src_sel = 2'd3;
        idle(L2 + 3);
        check(busy_rej_cnt_o == 2, "R7", "no extra starts counted", int'(busy_rej_cnt_o), 2);
        // R12: run_en low ignores starts and rewinds the program
        @(negedge clk); run_en = 0;
        sw_start(c0);
        idle(L2 + 3);
        check(busy_rej_cnt_o == 2, "R12", "ignored start not counted", int'(busy_rej_cnt_o), 2);
        run_en = 1;
        run_entry(9, 0);
        idle(5);
        check(q.size() == 0, "R4", "missing expected pulses", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule